// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block is the processor-facing port of a display controller. A host sends command bytes and display-data bytes to it over one of three links. Two of them are parallel byte buses: one with separate active-low read and write strobes (8080 style), and one with an active-high enable and a read/write direction line (6800 style). The third is a two-wire clocked serial link that reuses the top two data-bus pins. Two strap inputs pick the link. They are captured once after reset.

Access is gated by a pair of chip selects of opposite polarity. An address line tags each byte as a command or as display data. Every accepted byte leaves the block as a single-cycle write-valid pulse in the system clock domain, together with the byte and its tag. On parallel reads the block enables its bus drivers and presents a read byte supplied by the core. All host-side inputs cross into the system clock through two-flop synchronisers. Reset is asynchronous and active low, and its release is synchronised.

Top module: `hostbus_if`

## Requirements
- R1: A transfer is accepted only while `cs_n` is 0 and `cs` is 1. Any strobe activity outside that condition produces no write pulse and no bus drive.
- R2: The straps `par_sel` (1 = parallel, 0 = serial) and `m68_sel` (1 = 6800 style, 0 = 8080 style) are captured at the first clock after reset releases. Later changes have no effect until the next reset.
- R3: In 8080 mode, a write is captured on the rising edge of `wr_rw` (active-low write strobe). `wr_data` equals the bus value held around that edge.
- R4: In 8080 mode, `bus_oe` is 1 while the block is selected and `rd_e` (active-low read strobe) is 0. `bus_o` carries `rd_byte`.
- R5: In 6800 mode, a write is captured on the falling edge of `rd_e` (enable) while `wr_rw` is 0 (write).
- R6: In 6800 mode, `bus_oe` is 1 while the block is selected, `rd_e` is 1 and `wr_rw` is 1 (read). It is 0 while enable is low.
- R7: `wr_is_data` is 1 when `dc_sel` was 1 for the byte (display data) and 0 when it was 0 (command).
- R8: In serial mode, `bus_i[6]` is the serial clock and `bus_i[7]` is the serial data. Bits are taken MSB first on rising clock edges. The eighth bit completes the byte, and `dc_sel` is sampled with that bit. `bus_i[5:0]` are ignored.
- R9: The serial bit counter returns to zero whenever the chip select is inactive. After a deselect, the next eight bits form a fresh byte.
- R10: `bus_oe` is 0 in serial mode and whenever the block is not selected.
- R11: While `rst_n` is 0, `bus_oe` and `wr_valid` are 0.
- R12: Each completed write gives exactly one `wr_valid` pulse, and that pulse lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | Strap: 1 parallel, 0 serial |
| m68_sel | input | 1 | Strap: 1 6800 style, 0 8080 style |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| rd_e | input | 1 | 8080: read strobe (low active); 6800: enable |
| wr_rw | input | 1 | 8080: write strobe (low active); 6800: read/write (1 read) |
| dc_sel | input | 1 | 1 display data, 0 command |
| bus_i | input | DW | Data bus input; bits 7/6 are serial data/clock |
| rd_byte | input | DW | Byte returned on parallel reads |
| bus_o | output | DW | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| wr_valid | output | 1 | One-cycle pulse per accepted byte |
| wr_data | output | DW | Accepted byte |
| wr_is_data | output | 1 | Tag of accepted byte |

## Verification
A wrong strap capture shows up in the first transfer after reset. Either no pulse arrives, or `bus_oe` follows the wrong strobe, within about four clocks of the strobe edge. A serial counter that is out of step does not fail at once. It shows as a shifted byte, or a missing pulse, at the next eighth clock rise, so the bench breaks a byte off with a deselect and then checks the byte that follows. An edge detector that is out of step shows as a duplicated or missing pulse, so pulse counts are compared after every transfer.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    HB_I80 = 2'd0,
    HB_M68 = 2'd1,
    HB_SER = 2'd2
  } hb_mode_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/hb_par.sv
module hb_par #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          m68,
  input  logic          sel,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic          dc,
  input  logic [DW-1:0] bus,
  output logic          evt,
  output logic [DW-1:0] evt_data,
  output logic          evt_dc,
  output logic          oe_req
);
  logic a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= strb_a;
      b_q <= strb_b;
    end
  end

  always_comb begin
    if (m68) begin
      evt    = en & sel & a_q & ~strb_a & ~strb_b;
      oe_req = en & sel & strb_a & strb_b;
    end else begin
      evt    = en & sel & strb_b & ~b_q;
      oe_req = en & sel & ~strb_a;
    end
    evt_data = bus;
    evt_dc   = dc;
  end
endmodule

// File: rtl/hb_ser.sv
module hb_ser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          dc,
  output logic          evt,
  output logic [DW-1:0] evt_data,
  output logic          evt_dc
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_q;
  logic [DW-2:0] sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = en & sel & sclk & ~sck_q;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    evt   = 1'b0;
    if (!sel) begin
      cnt_d = '0;
    end else if (rise) begin
      sr_d = {sr_q[DW-3:0], sdi};
      if (cnt_q == LAST) begin
        evt   = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    evt_data = {sr_q, sdi};
    evt_dc   = dc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_q <= sclk;
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  // R9
  ser_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == '0));
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
  import hb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_sel,
  input  logic          m68_sel,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          rd_e,
  input  logic          wr_rw,
  input  logic          dc_sel,
  input  logic [DW-1:0] bus_i,
  input  logic [DW-1:0] rd_byte,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          wr_is_data
);
  localparam int SCK_BIT = DW - 2;
  localparam int SDI_BIT = DW - 1;
  localparam int SW      = DW + 5;
  localparam int WARM    = SYNC_STAGES + 1;
  localparam int WW      = $clog2(WARM + 1);
  localparam logic [WW-1:0] WARM_V = WW'(WARM);

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  // strap capture and warm-up window
  hb_mode_e      mode_q, mode_d;
  logic          lock_q;
  logic [WW-1:0] warm_q, warm_d;
  logic          ready;

  always_comb begin
    mode_d = mode_q;
    if (!lock_q) mode_d = par_sel ? (m68_sel ? HB_M68 : HB_I80) : HB_SER;
    warm_d = (warm_q == WARM_V) ? warm_q : warm_q + 1'b1;
  end
  assign ready = (warm_q == WARM_V);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= HB_I80;
      lock_q <= 1'b0;
      warm_q <= '0;
    end else begin
      mode_q <= mode_d;
      lock_q <= 1'b1;
      warm_q <= warm_d;
    end
  end

  // host input synchronisers
  logic [SW-1:0]  raw_v, syn_v;
  logic           cs_n_s, cs_s, rd_s, wr_s, dc_s, sel_s;
  logic [DW-1:0]  bus_s;

  assign raw_v = {cs_n, cs, rd_e, wr_rw, dc_sel, bus_i};

  hb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_s_n), .d (raw_v), .q (syn_v)
  );

  assign {cs_n_s, cs_s, rd_s, wr_s, dc_s, bus_s} = syn_v;
  assign sel_s = ~cs_n_s & cs_s;

  // protocol engines
  logic          p_evt, p_dc, p_oe, s_evt, s_dc;
  logic [DW-1:0] p_data, s_data;

  hb_par #(.DW(DW)) u_par (
    .clk (clk), .rst_n (rst_s_n),
    .en (ready & (mode_q != HB_SER)), .m68 (mode_q == HB_M68),
    .sel (sel_s), .strb_a (rd_s), .strb_b (wr_s), .dc (dc_s), .bus (bus_s),
    .evt (p_evt), .evt_data (p_data), .evt_dc (p_dc), .oe_req (p_oe)
  );

  hb_ser #(.DW(DW)) u_ser (
    .clk (clk), .rst_n (rst_s_n),
    .en (ready & (mode_q == HB_SER)), .sel (sel_s),
    .sclk (bus_s[SCK_BIT]), .sdi (bus_s[SDI_BIT]), .dc (dc_s),
    .evt (s_evt), .evt_data (s_data), .evt_dc (s_dc)
  );

  // output stage
  logic          vld_q, vld_d, dc_q, dc_d, oe_q, oe_d;
  logic [DW-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = 1'b0;
    dat_d = dat_q;
    dc_d  = dc_q;
    if (p_evt) begin
      vld_d = 1'b1;
      dat_d = p_data;
      dc_d  = p_dc;
    end else if (s_evt) begin
      vld_d = 1'b1;
      dat_d = s_data;
      dc_d  = s_dc;
    end
    oe_d = p_oe & (mode_q != HB_SER);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      dc_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      dc_q  <= dc_d;
      oe_q  <= oe_d;
    end
  end

  assign wr_valid   = vld_q;
  assign wr_data    = dat_q;
  assign wr_is_data = dc_q;
  assign bus_oe     = oe_q;
  assign bus_o      = rd_byte;

  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_valid |=> !wr_valid);
  // R10
  oe_serial_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_oe |-> (mode_q != HB_SER));
  // R11
  oe_reset_chk: assert property (@(posedge clk)
    !rst_n |-> (!bus_oe && !wr_valid));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(lock_q) |-> $stable(mode_q));
endmodule

// File: tb/hostbus_if_tb.sv
module hostbus_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_sel = 1'b1, m68_sel = 1'b0;
  logic       cs_n = 1'b1, cs = 1'b0, rd_e = 1'b1, wr_rw = 1'b1, dc_sel = 1'b0;
  logic [7:0] bus_i = '0, rd_byte = 8'h96;
  logic [7:0] bus_o, wr_data;
  logic       bus_oe, wr_valid, wr_is_data;

  always #2 clk = ~clk;

  hostbus_if u_dut (
    .clk (clk), .rst_n (rst_n), .par_sel (par_sel), .m68_sel (m68_sel),
    .cs_n (cs_n), .cs (cs), .rd_e (rd_e), .wr_rw (wr_rw), .dc_sel (dc_sel),
    .bus_i (bus_i), .rd_byte (rd_byte), .bus_o (bus_o), .bus_oe (bus_oe),
    .wr_valid (wr_valid), .wr_data (wr_data), .wr_is_data (wr_is_data)
  );

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic [7:0] last_d = '0;
  logic       last_dc = 1'b0;

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      pulses++;
      last_d  = wr_data;
      last_dc = wr_is_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic p, input logic m);
    rst_n = 1'b0; par_sel = p; m68_sel = m;
    cs_n = 1'b1; cs = 1'b0; rd_e = m ? 1'b0 : 1'b1; wr_rw = 1'b1;
    dc_sel = 1'b0; bus_i = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(8);
  endtask

  task automatic i80_wr(input logic csn, input logic c, input logic dc, input logic [7:0] d);
    cs_n = csn; cs = c; dc_sel = dc; bus_i = d; cyc(3);
    wr_rw = 1'b0; cyc(4);
    wr_rw = 1'b1; cyc(4);
    cs_n = 1'b1; cs = 1'b0; cyc(3);
  endtask

  task automatic m68_wr(input logic dc, input logic [7:0] d);
    cs_n = 1'b0; cs = 1'b1; wr_rw = 1'b0; dc_sel = dc; bus_i = d; cyc(3);
    rd_e = 1'b1; cyc(4);
    rd_e = 1'b0; cyc(4);
    wr_rw = 1'b1; cs_n = 1'b1; cs = 1'b0; cyc(3);
  endtask

  task automatic ser_bits(input logic dc, input logic [7:0] d, input int n);
    cs_n = 1'b0; cs = 1'b1; dc_sel = dc;
    for (int i = 7; i > 7 - n; i--) begin
      bus_i = {d[i], 1'b0, 6'h2A}; cyc(2);
      bus_i[6] = 1'b1; cyc(2);
      bus_i[6] = 1'b0;
    end
    cyc(3);
  endtask

  task automatic ser_end();
    cs_n = 1'b1; cs = 1'b0; bus_i = '0; cyc(3);
  endtask

  // {mode (0 8080, 1 6800, 2 serial), dc, data}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b0, 8'hA5}, {2'd0, 1'b1, 8'h3C}, {2'd1, 1'b0, 8'h81},
    {2'd1, 1'b1, 8'h7E}, {2'd2, 1'b0, 8'hC3}, {2'd2, 1'b1, 8'h5A},
    {2'd2, 1'b1, 8'hFF}, {2'd0, 1'b1, 8'h00}
  };

  initial begin
    int p0;
    int cur;
    cyc(2);
    chk("R11 oe in reset", 32'(bus_oe), 32'd0);
    chk("R11 valid in reset", 32'(wr_valid), 32'd0);
    cur = -1;
    foreach (VEC[k]) begin
      int md;
      string rq;
      md = int'(VEC[k][10:9]);
      if (md != cur) begin
        do_reset(md != 2, md == 1);
        cur = md;
      end
      p0 = pulses;
      if (md == 0)      begin rq = "R3"; i80_wr(1'b0, 1'b1, VEC[k][8], VEC[k][7:0]); end
      else if (md == 1) begin rq = "R5"; m68_wr(VEC[k][8], VEC[k][7:0]); end
      else              begin rq = "R8"; ser_bits(VEC[k][8], VEC[k][7:0], 8); ser_end(); end
      chk("R12 one pulse", 32'(pulses - p0), 32'd1);
      chk(rq, 32'(last_d), 32'(VEC[k][7:0]));
      chk("R7 tag", 32'(last_dc), 32'(VEC[k][8]));
    end

    // R1: either chip select inactive blocks a write
    do_reset(1'b1, 1'b0);
    p0 = pulses;
    i80_wr(1'b1, 1'b1, 1'b1, 8'h11);
    i80_wr(1'b0, 1'b0, 1'b1, 8'h22);
    chk("R1 deselected write", 32'(pulses - p0), 32'd0);

    // R4 / R10: 8080 read
    cs_n = 1'b0; cs = 1'b0; rd_e = 1'b0; cyc(5);
    chk("R10 oe deselected", 32'(bus_oe), 32'd0);
    cs = 1'b1; cyc(5);
    chk("R4 oe on read", 32'(bus_oe), 32'd1);
    chk("R4 read byte", 32'(bus_o), 32'h96);
    rd_e = 1'b1; cyc(5);
    chk("R4 oe released", 32'(bus_oe), 32'd0);

    // R2: strap change after lock is ignored
    par_sel = 1'b0; m68_sel = 1'b1;
    rd_e = 1'b0; cyc(5);
    chk("R2 still 8080 read", 32'(bus_oe), 32'd1);
    rd_e = 1'b1; cyc(2);
    p0 = pulses;
    i80_wr(1'b0, 1'b1, 1'b0, 8'h6D);
    chk("R2 still 8080 write", 32'(last_d), 32'h6D);

    // R11: async reset while driving
    cs_n = 1'b0; cs = 1'b1; rd_e = 1'b0; cyc(5);
    rst_n = 1'b0; #1;
    chk("R11 oe drops in reset", 32'(bus_oe), 32'd0);
    cyc(2);

    // R6: 6800 read
    do_reset(1'b1, 1'b1);
    cs_n = 1'b0; cs = 1'b1; wr_rw = 1'b1; rd_e = 1'b1; cyc(5);
    chk("R6 oe on read", 32'(bus_oe), 32'd1);
    rd_e = 1'b0; cyc(5);
    chk("R6 oe enable low", 32'(bus_oe), 32'd0);
    cs_n = 1'b1; cs = 1'b0; cyc(3);

    // R10 / R9: serial mode
    do_reset(1'b0, 1'b0);
    cs_n = 1'b0; cs = 1'b1; rd_e = 1'b0; cyc(5);
    chk("R10 oe serial", 32'(bus_oe), 32'd0);
    rd_e = 1'b1; ser_end();
    p0 = pulses;
    ser_bits(1'b0, 8'hE0, 3);
    ser_end();
    chk("R9 partial no pulse", 32'(pulses - p0), 32'd0);
    ser_bits(1'b1, 8'h4B, 8);
    ser_end();
    chk("R9 pulse after restart", 32'(pulses - p0), 32'd1);
    chk("R9 fresh byte", 32'(last_d), 32'h4B);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule